// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one data-port channel of a parallel I/O unit working in strobed handshake mode. The channel's direction is fixed at configuration time. As an input channel, a peripheral pulls its active-low strobe to capture a byte into an input latch. The channel then raises a buffer-full flag, and the CPU drains the latch with a read. As an output channel, a CPU write loads an output latch and asserts an active-low buffer-full line. The peripheral then answers with an active-low acknowledge. In both directions an interrupt request is raised when the channel needs service, gated by an interrupt-enable flag.

The interrupt-enable flag is changed by single-bit set/reset commands aimed at a port C bit number. That bit number depends on which port the channel serves and on its direction. The channel also supplies its share of the port C status word and a mask of the port C bits it owns. The four strobe lines (peripheral strobe, acknowledge, CPU read, CPU write) are asynchronous. Each passes through a two-stage synchronizer, and edges are detected on the synchronized copies. Address decoding and control-word parsing stay outside: the block receives an already-decoded mode-set pulse, a direction bit and the decoded read/write strobes of its own port.

Top module: `strobe_port_channel`

## Requirements
- R1: While reset is asserted, and in the clock after a `mode_set` pulse, the following hold: both data latches read zero, `in_full` is 0, `out_full_n` is 1, `intr` is 0, and interrupt enable is 0. `dir_in` may change only in a cycle where `mode_set` is high.
- R2: With `dir_in`=1, `per_din` is captured into the input latch in the clock where the synchronized strobe is first seen low. `cpu_rdata` shows the input latch.
- R3: With `dir_in`=1, `in_full` is set while the synchronized strobe is low. It is cleared by the rising edge of the synchronized read. If both happen in the same clock, the strobe wins.
- R4: With `dir_in`=1, `intr` is set when the strobe is high, the read is high and not just rising, `in_full` is 1 and enable is 1. It is cleared by the falling edge of the read, or when enable is 0.
- R5: With `dir_in`=0, the rising edge of the synchronized write captures `cpu_wdata` into the output latch, which drives `per_dout` and `cpu_rdata`. The same edge drives `out_full_n` low.
- R6: With `dir_in`=0, `out_full_n` returns high while the synchronized acknowledge is low, unless a write rising edge falls in the same clock.
- R7: With `dir_in`=0, `intr` is set when the acknowledge is high, the write is high and not just rising, `out_full_n` is 1 and enable is 1. It is cleared by the falling edge of the write, or when enable is 0.
- R8: A set/reset command (`bsr_valid`, `bsr_bit`, `bsr_val`) writes `bsr_val` into the enable flag only when `bsr_bit` equals the enable slot. The slot is 4 for port A input, 6 for port A output, and 2 for port B in either direction. Commands to any other bit have no effect.
- R9: `pc_stat` and `pc_own` carry the channel's share of port C; all other bits are 0. For port A input: bit 3 = `intr`, bit 4 = enable, bit 5 = `in_full`. For port A output: bit 3 = `intr`, bit 6 = enable, bit 7 = `out_full_n`. For port B: bit 0 = `intr`, bit 1 = `in_full` or `out_full_n`, bit 2 = enable.
- R10: A level change on any of the four strobe pins first affects the flags after the third rising clock edge following it (two synchronizer stages plus the edge register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_set | input | 1 | Decoded mode-set pulse; clears all channel state |
| dir_in | input | 1 | 1 = input channel, 0 = output channel |
| bsr_valid | input | 1 | Single-bit set/reset command strobe |
| bsr_bit | input | 3 | Port C bit number addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| cpu_rd_n | input | 1 | Active-low read of this port (asynchronous) |
| cpu_wr_n | input | 1 | Active-low write of this port (asynchronous) |
| cpu_wdata | input | DATA_W | Write data from the CPU |
| cpu_rdata | output | DATA_W | Latch contents presented to the CPU |
| per_stb_n | input | 1 | Active-low peripheral strobe (asynchronous) |
| per_ack_n | input | 1 | Active-low peripheral acknowledge (asynchronous) |
| per_din | input | DATA_W | Peripheral input data |
| per_dout | output | DATA_W | Output latch toward the peripheral |
| in_full | output | 1 | Input buffer full |
| out_full_n | output | 1 | Active-low output buffer full |
| intr | output | 1 | Interrupt request |
| pc_stat | output | 8 | Channel share of the port C status word |
| pc_own | output | 8 | Mask of port C bits owned by the channel |

## Verification
The bench builds two copies side by side on shared stimulus: one with `IS_PORT_A`=1 and one with `IS_PORT_A`=0. This covers both enable slots and both status layouts, and lets a command aimed at one slot be seen to leave the other copy untouched. `DATA_W` and `SYNC_STAGES` keep their defaults, so the three-edge latency of R10 and the ordering of read and write edges against the flag updates are checked exactly. After directed sequences in each direction, long stretches of random strobe, data and command traffic are run, with occasional mode changes.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int PC_W     = 8;
    localparam int PC_IDX_W = 3;

    typedef struct packed {
        logic ibf;   // input buffer holds unread data
        logic obf;   // output buffer holds data not yet acknowledged (active high inside)
        logic intr;  // interrupt request
        logic inte;  // interrupt enable
    } hs_flags_t;

    // port C bit that carries the interrupt enable for this channel
    function automatic logic [PC_IDX_W-1:0] enable_slot(input logic is_a, input logic dir_in);
        if (!is_a)
            return PC_IDX_W'(2);
        return dir_in ? PC_IDX_W'(4) : PC_IDX_W'(6);
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int               WIDTH  = 4,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] lvl
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= {STAGES{IDLE}};
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl = s_q.chain[STAGES-1];

endmodule

// File: rtl/hs_core.sv
module hs_core
    import hs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit IS_A   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_set,
    input  logic                dir_in,
    input  logic                bsr_valid,
    input  logic [PC_IDX_W-1:0] bsr_bit,
    input  logic                bsr_val,
    input  logic                stb_lvl,
    input  logic                ack_lvl,
    input  logic                rd_lvl,
    input  logic                wr_lvl,
    input  logic [DATA_W-1:0]   per_din,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   in_lat,
    output logic [DATA_W-1:0]   out_lat,
    output hs_flags_t           flags
);

    typedef struct packed {
        logic [DATA_W-1:0] in_lat;
        logic [DATA_W-1:0] out_lat;
        hs_flags_t         flg;
        logic              p_stb;
        logic              p_rd;
        logic              p_wr;
    } core_t;

    core_t c_d, c_q;

    logic stb_fall, rd_rise, rd_fall, wr_rise, wr_fall;
    logic en_hit;

    always_comb begin
        stb_fall = c_q.p_stb & ~stb_lvl;
        rd_rise  = ~c_q.p_rd & rd_lvl;
        rd_fall  = c_q.p_rd & ~rd_lvl;
        wr_rise  = ~c_q.p_wr & wr_lvl;
        wr_fall  = c_q.p_wr & ~wr_lvl;
        en_hit   = bsr_valid && (bsr_bit == enable_slot(IS_A, dir_in));

        c_d       = c_q;
        c_d.p_stb = stb_lvl;
        c_d.p_rd  = rd_lvl;
        c_d.p_wr  = wr_lvl;

        if (mode_set) begin
            c_d.in_lat  = '0;
            c_d.out_lat = '0;
            c_d.flg     = '0;
        end else begin
            if (en_hit) begin
                c_d.flg.inte = bsr_val;
            end
            if (dir_in) begin
                if (stb_fall) begin
                    c_d.in_lat = per_din;
                end
                if (!stb_lvl) begin
                    c_d.flg.ibf = 1'b1;
                end else if (rd_rise) begin
                    c_d.flg.ibf = 1'b0;
                end
                c_d.flg.intr = c_q.flg.inte & ~rd_fall &
                               (c_q.flg.intr | (stb_lvl & rd_lvl & ~rd_rise & c_q.flg.ibf));
            end else begin
                if (wr_rise) begin
                    c_d.out_lat = cpu_wdata;
                    c_d.flg.obf = 1'b1;
                end else if (!ack_lvl) begin
                    c_d.flg.obf = 1'b0;
                end
                c_d.flg.intr = c_q.flg.inte & ~wr_fall &
                               (c_q.flg.intr | (ack_lvl & wr_lvl & ~wr_rise & ~c_q.flg.obf));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.in_lat  <= '0;
            c_q.out_lat <= '0;
            c_q.flg     <= '0;
            c_q.p_stb   <= 1'b1;
            c_q.p_rd    <= 1'b1;
            c_q.p_wr    <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign in_lat  = c_q.in_lat;
    assign out_lat = c_q.out_lat;
    assign flags   = c_q.flg;

    // R1
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_set |=> (flags == '0 && in_lat == '0 && out_lat == '0));

    // R2
    in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && !mode_set && c_q.p_stb && !stb_lvl) |=> (in_lat == $past(per_din)));

    // R4
    in_intr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && $stable(dir_in) && flags.intr) |-> flags.ibf);

    // R5
    out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_in && !mode_set && !c_q.p_wr && wr_lvl) |=> (flags.obf && out_lat == $past(cpu_wdata)));

    // R7
    out_intr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_in && $stable(dir_in) && flags.intr) |-> !flags.obf);

    // R8
    inte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_set && !en_hit) |=> $stable(flags.inte));

endmodule

// File: rtl/hs_stat_map.sv
module hs_stat_map
    import hs_pkg::*;
#(
    parameter bit IS_A = 1'b1
) (
    input  logic            dir_in,
    input  hs_flags_t       flags,
    output logic [PC_W-1:0] stat,
    output logic [PC_W-1:0] own
);

    generate
        if (IS_A) begin : g_port_a
            always_comb begin
                stat    = '0;
                own     = '0;
                own[3]  = 1'b1;
                stat[3] = flags.intr;
                if (dir_in) begin
                    own[4]  = 1'b1;
                    own[5]  = 1'b1;
                    stat[4] = flags.inte;
                    stat[5] = flags.ibf;
                end else begin
                    own[6]  = 1'b1;
                    own[7]  = 1'b1;
                    stat[6] = flags.inte;
                    stat[7] = ~flags.obf;
                end
            end
        end else begin : g_port_b
            always_comb begin
                stat      = '0;
                own       = '0;
                own[2:0]  = 3'b111;
                stat[0]   = flags.intr;
                stat[1]   = dir_in ? flags.ibf : ~flags.obf;
                stat[2]   = flags.inte;
            end
        end
    endgenerate

    // R9
    stat_owned_chk: assert final ((stat & ~own) == '0);

endmodule

// File: rtl/strobe_port_channel.sv
module strobe_port_channel
    import hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit IS_PORT_A   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  logic              dir_in,
    input  logic              bsr_valid,
    input  logic [2:0]        bsr_bit,
    input  logic              bsr_val,
    input  logic              cpu_rd_n,
    input  logic              cpu_wr_n,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              per_stb_n,
    input  logic              per_ack_n,
    input  logic [DATA_W-1:0] per_din,
    output logic [DATA_W-1:0] per_dout,
    output logic              in_full,
    output logic              out_full_n,
    output logic              intr,
    output logic [7:0]        pc_stat,
    output logic [7:0]        pc_own
);

    localparam int NSIG = 4;

    logic [NSIG-1:0]   lines_sync;
    logic [DATA_W-1:0] in_lat, out_lat;
    hs_flags_t         flags;

    hs_sync #(
        .WIDTH  (NSIG),
        .STAGES (SYNC_STAGES),
        .IDLE   ({NSIG{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({cpu_wr_n, cpu_rd_n, per_ack_n, per_stb_n}),
        .lvl   (lines_sync)
    );

    hs_core #(
        .DATA_W (DATA_W),
        .IS_A   (IS_PORT_A)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_set  (mode_set),
        .dir_in    (dir_in),
        .bsr_valid (bsr_valid),
        .bsr_bit   (bsr_bit),
        .bsr_val   (bsr_val),
        .stb_lvl   (lines_sync[0]),
        .ack_lvl   (lines_sync[1]),
        .rd_lvl    (lines_sync[2]),
        .wr_lvl    (lines_sync[3]),
        .per_din   (per_din),
        .cpu_wdata (cpu_wdata),
        .in_lat    (in_lat),
        .out_lat   (out_lat),
        .flags     (flags)
    );

    hs_stat_map #(
        .IS_A (IS_PORT_A)
    ) u_stat (
        .dir_in (dir_in),
        .flags  (flags),
        .stat   (pc_stat),
        .own    (pc_own)
    );

    assign cpu_rdata  = dir_in ? in_lat : out_lat;
    assign per_dout   = out_lat;
    assign in_full    = flags.ibf;
    assign out_full_n = ~flags.obf;
    assign intr       = flags.intr;

endmodule

// File: tb/sim_strobe_port_channel.sv
`timescale 1ns/1ps
module sim_strobe_port_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_set = 1'b0;
    logic       dir_in = 1'b1;
    logic       bsr_valid = 1'b0;
    logic [2:0] bsr_bit = 3'd0;
    logic       bsr_val = 1'b0;
    logic       cpu_rd_n = 1'b1;
    logic       cpu_wr_n = 1'b1;
    logic [7:0] cpu_wdata = 8'h00;
    logic       per_stb_n = 1'b1;
    logic       per_ack_n = 1'b1;
    logic [7:0] per_din = 8'h00;

    logic [7:0] d_rdata [2];
    logic [7:0] d_dout  [2];
    logic       d_full  [2];
    logic       d_ofn   [2];
    logic       d_intr  [2];
    logic [7:0] d_stat  [2];
    logic [7:0] d_own   [2];

    always #2.5 clk = ~clk;

    strobe_port_channel #(.IS_PORT_A(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .dir_in(dir_in),
        .bsr_valid(bsr_valid), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata), .cpu_rdata(d_rdata[0]),
        .per_stb_n(per_stb_n), .per_ack_n(per_ack_n), .per_din(per_din), .per_dout(d_dout[0]),
        .in_full(d_full[0]), .out_full_n(d_ofn[0]), .intr(d_intr[0]),
        .pc_stat(d_stat[0]), .pc_own(d_own[0]));

    strobe_port_channel #(.IS_PORT_A(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .dir_in(dir_in),
        .bsr_valid(bsr_valid), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata), .cpu_rdata(d_rdata[1]),
        .per_stb_n(per_stb_n), .per_ack_n(per_ack_n), .per_din(per_din), .per_dout(d_dout[1]),
        .in_full(d_full[1]), .out_full_n(d_ofn[1]), .intr(d_intr[1]),
        .pc_stat(d_stat[1]), .pc_own(d_own[1]));

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_en  = 1'b0;

    task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_in  [2];
    logic [7:0] m_out [2];
    bit m_ibf [2], m_obf [2], m_intr [2], m_inte [2];
    bit q_wr[$], q_rd[$], q_ack[$], q_stb[$];   // pin history, front = oldest
    bit o_wr, o_rd, o_stb;                    // level seen one clock earlier

    function automatic int slot_of(int i, bit din);
        if (i == 1) return 2;
        return din ? 4 : 6;
    endfunction

    function automatic logic [7:0] exp_stat(int i, bit din, bit ibf, bit obf, bit irq, bit ie);
        logic [7:0] r = 8'h00;
        if (i == 0) begin
            r[3] = irq;
            if (din) begin r[4] = ie; r[5] = ibf; end
            else     begin r[6] = ie; r[7] = !obf; end
        end else begin
            r[0] = irq; r[2] = ie; r[1] = din ? ibf : !obf;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_own(int i, bit din);
        if (i == 1) return 8'h07;
        return din ? 8'h38 : 8'hC8;
    endfunction

    always @(posedge clk) begin : model
        bit s_stb, s_ack, s_rd, s_wr;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_in[i] = 0; m_out[i] = 0; m_ibf[i] = 0; m_obf[i] = 0; m_intr[i] = 0; m_inte[i] = 0;
            end
            q_wr = '{1, 1}; q_rd = '{1, 1}; q_ack = '{1, 1}; q_stb = '{1, 1};
            o_wr = 1; o_rd = 1; o_stb = 1;
        end else begin
            s_stb = q_stb[0]; s_ack = q_ack[0]; s_rd = q_rd[0]; s_wr = q_wr[0];
            for (int i = 0; i < 2; i++) begin
                bit rdr, rdf, wrr, wrf, stf;
                rdr = !o_rd && s_rd;  rdf = o_rd && !s_rd;
                wrr = !o_wr && s_wr;  wrf = o_wr && !s_wr;
                stf = o_stb && !s_stb;
                if (mode_set) begin
                    m_in[i] = 0; m_out[i] = 0; m_ibf[i] = 0; m_obf[i] = 0; m_intr[i] = 0; m_inte[i] = 0;
                end else begin
                    bit old_ie, n_intr, n_ibf, n_obf;
                    old_ie = m_inte[i];
                    if (bsr_valid && int'(bsr_bit) == slot_of(i, dir_in)) m_inte[i] = bsr_val;
                    if (dir_in) begin
                        if (stf) m_in[i] = per_din;
                        n_ibf = m_ibf[i];
                        if (!s_stb) n_ibf = 1; else if (rdr) n_ibf = 0;
                        n_intr = old_ie && !rdf && (m_intr[i] || (s_stb && s_rd && !rdr && m_ibf[i]));
                        m_ibf[i] = n_ibf; m_intr[i] = n_intr;
                    end else begin
                        n_obf = m_obf[i];
                        if (wrr) begin m_out[i] = cpu_wdata; n_obf = 1; end
                        else if (!s_ack) n_obf = 0;
                        n_intr = old_ie && !wrf && (m_intr[i] || (s_ack && s_wr && !wrr && !m_obf[i]));
                        m_obf[i] = n_obf; m_intr[i] = n_intr;
                    end
                end
            end
            o_wr = s_wr; o_rd = s_rd; o_stb = s_stb;
            void'(q_wr.pop_front()); void'(q_rd.pop_front());
            void'(q_ack.pop_front()); void'(q_stb.pop_front());
            q_wr.push_back(cpu_wr_n); q_rd.push_back(cpu_rd_n);
            q_ack.push_back(per_ack_n); q_stb.push_back(per_stb_n);
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            for (int i = 0; i < 2; i++) begin
                chk(d_rdata[i] == (dir_in ? m_in[i] : m_out[i]), dir_in ? "R2 cpu_rdata" : "R5 cpu_rdata",
                    d_rdata[i], dir_in ? m_in[i] : m_out[i]);
                chk(d_dout[i] == m_out[i], "R5 per_dout", d_dout[i], m_out[i]);
                chk(d_full[i] == m_ibf[i], "R3 in_full", d_full[i], m_ibf[i]);
                chk(d_ofn[i] == !m_obf[i], "R6 out_full_n", d_ofn[i], !m_obf[i]);
                chk(d_intr[i] == m_intr[i], dir_in ? "R4 intr" : "R7 intr", d_intr[i], m_intr[i]);
                chk(d_stat[i] == exp_stat(i, dir_in, m_ibf[i], m_obf[i], m_intr[i], m_inte[i]),
                    "R9 pc_stat", d_stat[i], exp_stat(i, dir_in, m_ibf[i], m_obf[i], m_intr[i], m_inte[i]));
                chk(d_own[i] == exp_own(i, dir_in), "R9 pc_own", d_own[i], exp_own(i, dir_in));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_mode(input bit din);
        @(negedge clk); mode_set = 1; dir_in = din;
        @(negedge clk); mode_set = 0;
    endtask

    task automatic do_bsr(input int b, input bit v);
        @(negedge clk); bsr_valid = 1; bsr_bit = 3'(b); bsr_val = v;
        @(negedge clk); bsr_valid = 0;
    endtask

    task automatic pulse_stb(input logic [7:0] data);
        @(negedge clk); per_din = data; per_stb_n = 0;
        idle(3); per_stb_n = 1; idle(4);
    endtask

    task automatic pulse_rd();
        @(negedge clk); cpu_rd_n = 0;
        idle(3); cpu_rd_n = 1; idle(4);
    endtask

    task automatic pulse_wr(input logic [7:0] data);
        @(negedge clk); cpu_wdata = data; cpu_wr_n = 0;
        idle(3); cpu_wr_n = 1; idle(4);
    endtask

    task automatic pulse_ack();
        @(negedge clk); per_ack_n = 0;
        idle(3); per_ack_n = 1; idle(4);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired act=%0d exp=0", n_tests);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(d_full[0] == 0 && d_intr[0] == 0 && d_ofn[0] == 1, "R1 reset flags", {d_full[0], d_intr[0], d_ofn[0]}, 3'b001);
        chk(d_rdata[0] == 0 && d_dout[1] == 0, "R1 reset latches", {d_rdata[0], d_dout[1]}, 0);
        chk(d_stat[0] == 0 && d_stat[1] == 0, "R1 reset status", {d_stat[0], d_stat[1]}, 0);
        cmp_en = 1;

        // input direction
        do_mode(1);
        // R8 wrong slot has no effect
        do_bsr(6, 1);
        idle(1);
        chk(d_stat[0][4] == 0 && d_stat[1][2] == 0, "R8 foreign slot", {d_stat[0][4], d_stat[1][2]}, 0);
        do_bsr(4, 1);
        idle(1);
        chk(d_stat[0][4] == 1 && d_stat[1][2] == 0, "R8 slot 4 port A", {d_stat[0][4], d_stat[1][2]}, 2'b10);
        do_bsr(2, 1);
        idle(1);
        chk(d_stat[1][2] == 1, "R8 slot 2 port B", d_stat[1][2], 1);

        // R10 latency on strobe
        @(negedge clk); per_din = 8'hA5; per_stb_n = 0;
        @(negedge clk); chk(d_full[0] == 0, "R10 edge 1", d_full[0], 0);
        @(negedge clk); chk(d_full[0] == 0, "R10 edge 2", d_full[0], 0);
        @(negedge clk); chk(d_full[0] == 1, "R10 edge 3", d_full[0], 1);
        chk(d_rdata[0] == 8'hA5, "R2 capture", d_rdata[0], 8'hA5);
        per_stb_n = 1; idle(5);
        chk(d_intr[0] == 1 && d_intr[1] == 1, "R4 intr raised", {d_intr[0], d_intr[1]}, 2'b11);
        pulse_rd();
        chk(d_full[0] == 0 && d_intr[0] == 0, "R3 read clears", {d_full[0], d_intr[0]}, 0);
        do_bsr(4, 0);
        pulse_stb(8'h3C);
        chk(d_intr[0] == 0 && d_intr[1] == 1, "R4 enable gates intr", {d_intr[0], d_intr[1]}, 2'b01);
        pulse_rd();

        // output direction
        do_mode(0);
        idle(1);
        chk(d_ofn[0] == 1 && d_rdata[0] == 0 && d_stat[0][4] == 0, "R1 mode clears", {d_ofn[0], d_rdata[0]}, 9'h100);
        do_bsr(6, 1);
        do_bsr(2, 1);
        idle(2);
        chk(d_intr[0] == 1 && d_intr[1] == 1, "R7 empty intr", {d_intr[0], d_intr[1]}, 2'b11);
        pulse_wr(8'h5A);
        chk(d_ofn[0] == 0 && d_dout[0] == 8'h5A && d_intr[0] == 0, "R5 write loads", {d_ofn[0], d_dout[0], d_intr[0]}, 10'h0B4);
        pulse_ack();
        chk(d_ofn[0] == 1 && d_intr[0] == 1, "R6 ack frees", {d_ofn[0], d_intr[0]}, 2'b11);
        pulse_wr(8'hC3);
        chk(d_stat[0][7] == 0 && d_stat[1][1] == 0, "R9 obf status", {d_stat[0][7], d_stat[1][1]}, 0);
        pulse_ack();

        // random traffic, both directions
        for (int ph = 0; ph < 4; ph++) begin
            do_mode(ph[0] == 0);
            for (int c = 0; c < 1500; c++) begin
                @(negedge clk);
                per_din   = 8'($urandom);
                cpu_wdata = 8'($urandom);
                if ($urandom_range(0, 5) == 0) per_stb_n = ~per_stb_n;
                if ($urandom_range(0, 5) == 0) per_ack_n = ~per_ack_n;
                if ($urandom_range(0, 5) == 0) cpu_rd_n  = ~cpu_rd_n;
                if ($urandom_range(0, 5) == 0) cpu_wr_n  = ~cpu_wr_n;
                bsr_valid = ($urandom_range(0, 9) == 0);
                bsr_bit   = 3'($urandom);
                bsr_val   = ($urandom_range(0, 3) != 0);
                mode_set  = ($urandom_range(0, 499) == 0);
            end
            @(negedge clk);
            bsr_valid = 0; mode_set = 0;
            per_stb_n = 1; per_ack_n = 1; cpu_rd_n = 1; cpu_wr_n = 1;
            idle(6);
        end

        cmp_en = 0;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule